// File: doc/BRIEF.md
# Router Input FIFO with Transparent Periodic Self-Test

This block is the input buffer of one router channel. Flits are pushed into a small SRAM-style array and leave in arrival order; the head flit is always visible on `flit_out` while the buffer holds data. Write and read positions are kept by gray-coded pointers, and the full and empty flags come from comparing those pointers.

At a fixed interval the block switches into test mode, whatever the buffer currently holds. While `test_active` is high, multiplexers give the array's enables and addresses to a test sequencer. The sequencer walks every physical location in ascending order. At each location it reads the stored word, writes back its complement, reads the complement, writes the original word back, and reads it once more. Each read is compared with the value it should give, and any mismatch sets a sticky `fault` flag. Because every word is inverted twice, the stored flits survive the test. When the last location is done, normal operation resumes with the pointers where they were.

The router upstream and downstream must treat `test_active` as a stall: the buffer accepts no push or pop while it is high. The test runs on the router clock and uses one array operation per cycle, so it takes five cycles per location.

Top module: `tfifo_top`

## Requirements
- R1: Flits leave in the order they were accepted. While `empty` is low and `test_active` is low, `flit_out` shows the oldest stored flit, and a pop advances it in the next cycle.
- R2: `empty` is high exactly when no flits are held and `full` is high exactly when DEPTH flits are held. A push while full and a pop while empty are ignored. A push and a pop in the same cycle are both taken when neither is blocked.
- R3: `test_active` rises after PERIOD clock cycles spent out of test mode, counted from reset release or from the end of the previous test, whatever the fill level.
- R4: A test covers addresses 0 to DEPTH-1 in ascending order, with five one-cycle operations per address in the order read x, write not-x, read, write x, read. `test_active` is therefore high for exactly 5*DEPTH cycles.
- R5: After a test, every stored flit, the fill count and the read and write positions are the same as before it started.
- R6: While `test_active` is high, `push` and `pop` are ignored and `full` and `empty` keep the values they had when the test started.
- R7: `fault` is set when the second read of a location differs from the complement of the first read, or the third read differs from the first. It stays set until reset, and it stays low for a fault-free array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Router clock; also paces the self-test |
| rst_n | input | 1 | Synchronous active-low reset |
| push | input | 1 | Store `flit_in` this cycle (ignored when full or testing) |
| flit_in | input | DATA_W | Flit to store |
| pop | input | 1 | Remove the head flit this cycle (ignored when empty or testing) |
| flit_out | output | DATA_W | Head flit; valid while not empty and not testing |
| full | output | 1 | Buffer holds DEPTH flits |
| empty | output | 1 | Buffer holds no flits |
| test_active | output | 1 | Self-test in progress; the neighbours must stall |
| fault | output | 1 | Sticky mismatch flag from the self-test |

## Verification
A corrupted test address, a write slot in the wrong place or a wrong restore value changes a stored flit. This shows on `flit_out` the first time that flit reaches the head after the test, which is at most DEPTH pops later. It also raises `fault` within the same test, usually within five cycles of the wrong operation. An off-by-one in the period counter or in the slot sequence moves the rising or falling edge of `test_active` by at least one cycle, and the bench predicts both edges from the cycle count alone. A pointer disturbed by the test, or a push or pop that slips through during it, shows as wrong `full` or `empty` flags or out-of-order data in the cycles right after `test_active` falls.

// File: rtl/tfifo_pkg.sv
// Shared types for the transparent-test FIFO.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tfifo_pkg;

    // The five one-cycle operations applied to each location under test.
    typedef enum logic [2:0] {
        SLOT_RD_ORIG  = 3'd0,  // read original word x
        SLOT_WR_INV   = 3'd1,  // write not-x
        SLOT_RD_INV   = 3'd2,  // read back, expect not-x
        SLOT_WR_ORIG  = 3'd3,  // write x back
        SLOT_RD_FINAL = 3'd4   // read back, expect x
    } slot_e;

endpackage

// File: rtl/tfifo_gray_ptr.sv
// Binary counter with a gray-coded view, used for the FIFO write, read and
// test addresses. Assumes W >= 1. Wraps modulo 2**W.
module tfifo_gray_ptr #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] bin,
    output logic [W-1:0] gray
);

    logic [W-1:0] bin_q;

    // Counter state: clear has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) bin_q <= '0;
        else if (inc)      bin_q <= bin_q + 1'b1;
    end

    // Gray view of the count.
    assign bin  = bin_q;
    assign gray = bin_q ^ (bin_q >> 1);

endmodule

// File: rtl/tfifo_store.sv
// SRAM-style storage array: one synchronous write port, one combinational
// read port. Contents are not reset, as in a real SRAM macro.
module tfifo_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Array read.
    assign rdata = mem[raddr];

endmodule

// File: rtl/tfifo_test_seq.sv
// Period timer and transparent test sequencer. After PERIOD idle cycles it
// raises test_on, walks every address in ascending order with the five-slot
// read/invert/read/restore/read sequence and compares each read. Assumes
// the array read is combinational and PERIOD >= 1.
module tfifo_test_seq #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int PERIOD = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rdata,
    output logic              test_on,
    output logic [ADDR_W-1:0] t_addr,
    output logic              t_we,
    output logic [DATA_W-1:0] t_wdata,
    output logic              fault
);
    import tfifo_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = $clog2(PERIOD + 1);
    localparam logic [CW-1:0]     LAST_CNT  = CW'(PERIOD - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic [CW-1:0]     per_cnt;
    slot_e             slot;
    logic [DATA_W-1:0] x_q;
    logic [ADDR_W-1:0] addr_gray;
    logic              step_addr;
    logic              last_step;

    assign step_addr = test_on && (slot == SLOT_RD_FINAL);
    assign last_step = step_addr && (t_addr == LAST_ADDR);

    // Test address generator, held at zero outside a test.
    tfifo_gray_ptr #(.W(ADDR_W)) u_taddr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!test_on),
        .inc  (step_addr),
        .bin  (t_addr),
        .gray (addr_gray)
    );

    // Period timer and test-mode entry and exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt <= '0;
            test_on <= 1'b0;
        end else if (!test_on) begin
            if (per_cnt == LAST_CNT) begin
                per_cnt <= '0;
                test_on <= 1'b1;
            end else begin
                per_cnt <= per_cnt + 1'b1;
            end
        end else if (last_step) begin
            test_on <= 1'b0;
        end
    end

    // Slot sequencer: five operations per location.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_on)         slot <= SLOT_RD_ORIG;
        else if (slot == SLOT_RD_FINAL) slot <= SLOT_RD_ORIG;
        else                            slot <= slot_e'(slot + 3'd1);
    end

    // Capture of the original word on the first read.
    always_ff @(posedge clk) begin
        if (!rst_n)                              x_q <= '0;
        else if (test_on && slot == SLOT_RD_ORIG) x_q <= rdata;
    end

    // Sticky comparison of the second and third reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault <= 1'b0;
        end else if (test_on) begin
            if (slot == SLOT_RD_INV   && rdata != ~x_q) fault <= 1'b1;
            if (slot == SLOT_RD_FINAL && rdata !=  x_q) fault <= 1'b1;
        end
    end

    // Test write port: complement in the invert slot, original in restore.
    assign t_we    = test_on && (slot == SLOT_WR_INV || slot == SLOT_WR_ORIG);
    assign t_wdata = (slot == SLOT_WR_INV) ? ~x_q : x_q;

endmodule

// File: rtl/tfifo_top.sv
// Router input FIFO with periodic transparent self-test. Normal traffic
// uses gray-coded write and read pointers; during a test, multiplexers hand
// the array to the test sequencer and push/pop are ignored. Assumes DEPTH
// is a power of two and at least 4.
module tfifo_top #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int PERIOD = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] flit_in,
    input  logic              pop,
    output logic [DATA_W-1:0] flit_out,
    output logic              full,
    output logic              empty,
    output logic              test_active,
    output logic              fault
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0]     wr_bin, wr_gray, rd_bin, rd_gray;
    logic              push_ok, pop_ok;
    logic [AW-1:0]     t_addr;
    logic              t_we;
    logic [DATA_W-1:0] t_wdata;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    // Accepted operations: blocked by the flags and by test mode.
    assign push_ok = push && !full  && !test_active;
    assign pop_ok  = pop  && !empty && !test_active;

    tfifo_gray_ptr #(.W(PW)) u_wptr (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(push_ok),
        .bin(wr_bin), .gray(wr_gray)
    );

    tfifo_gray_ptr #(.W(PW)) u_rptr (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(pop_ok),
        .bin(rd_bin), .gray(rd_gray)
    );

    // Flags from the gray pointers; frozen during a test as pointers are.
    assign empty = (wr_gray == rd_gray);
    assign full  = (wr_gray == {~rd_gray[PW-1:PW-2], rd_gray[PW-3:0]});

    tfifo_test_seq #(.DATA_W(DATA_W), .ADDR_W(AW), .PERIOD(PERIOD)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .rdata  (mem_rdata),
        .test_on(test_active),
        .t_addr (t_addr),
        .t_we   (t_we),
        .t_wdata(t_wdata),
        .fault  (fault)
    );

    // Mode multiplexers on the array enables, addresses and write data.
    assign mem_we    = test_active ? t_we    : push_ok;
    assign mem_waddr = test_active ? t_addr  : wr_bin[AW-1:0];
    assign mem_wdata = test_active ? t_wdata : flit_in;
    assign mem_raddr = test_active ? t_addr  : rd_bin[AW-1:0];

    tfifo_store #(.DATA_W(DATA_W), .ADDR_W(AW)) u_store (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    assign flit_out = mem_rdata;

endmodule

// File: rtl/tfifo_checker.sv
// Port-level temporal checks for tfifo_top, attached by bind below.
// Uses cycle counters in place of long delays so large parameters stay cheap.
module tfifo_checker #(
    parameter int DEPTH  = 8,
    parameter int PERIOD = 64
) (
    input logic clk,
    input logic rst_n,
    input logic pop,
    input logic full,
    input logic empty,
    input logic test_active,
    input logic fault
);

    logic [31:0] idle_cnt, busy_cnt;

    // Cycles spent out of test mode and in test mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            busy_cnt <= '0;
        end else if (test_active) begin
            idle_cnt <= '0;
            busy_cnt <= busy_cnt + 1;
        end else begin
            idle_cnt <= idle_cnt + 1;
            busy_cnt <= '0;
        end
    end

    assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

    assert_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_active) |-> (idle_cnt == 32'(PERIOD)));

    assert_test_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_active) |-> (busy_cnt == 32'(5 * DEPTH)));

    assert_flags_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        test_active |=> ($stable(full) && $stable(empty)));

    assert_no_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fault);

endmodule

bind tfifo_top tfifo_checker #(.DEPTH(DEPTH), .PERIOD(PERIOD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop        (pop),
    .full       (full),
    .empty      (empty),
    .test_active(test_active),
    .fault      (fault)
);

// File: tb/tb_tfifo_top.sv
// Self-checking bench: a queue model and a closed-form schedule for
// test_active, compared every cycle against the ports.
module tb_tfifo_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 16;
    localparam int D     = 4;
    localparam int P     = 24;
    localparam int T     = 5 * D;
    localparam int NCYC  = 640;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push = 1'b0, pop = 1'b0;
    logic [DW-1:0] flit_in = '0;
    logic [DW-1:0] flit_out;
    logic          full, empty, test_active, fault;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [DW-1:0] q [D];
    int head = 0, cnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tfifo_top #(.DATA_W(DW), .DEPTH(D), .PERIOD(P)) dut (
        .clk(clk), .rst_n(rst_n), .push(push), .flit_in(flit_in), .pop(pop),
        .flit_out(flit_out), .full(full), .empty(empty),
        .test_active(test_active), .fault(fault)
    );

    // One comparison, counted and reported on mismatch.
    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        bit exp_act;
        bit do_push, do_pop;
        int phase;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R2, R3, R7).
        chk(empty == 1'b1, "R2 reset empty", 32'(empty), 1);
        chk(full == 1'b0, "R2 reset full", 32'(full), 0);
        chk(test_active == 1'b0, "R3 reset test_active", 32'(test_active), 0);
        chk(fault == 1'b0, "R7 reset fault", 32'(fault), 0);
        for (int n = 0; n < NCYC; n++) begin
            // n edges have passed since reset release.
            exp_act = ((n % (P + T)) >= P);
            chk(test_active == exp_act, "R3 R4 test_active schedule",
                32'(test_active), 32'(exp_act));
            // Flags must follow the model count, unchanged through a test (R6).
            chk(empty == (cnt == 0), "R2 R6 empty", 32'(empty), 32'(cnt == 0));
            chk(full == (cnt == D), "R2 R6 full", 32'(full), 32'(cnt == D));
            // Head flit, including right after a test (R1, R5).
            if (!exp_act && cnt > 0)
                chk(flit_out == q[head], "R1 R5 head flit", 32'(flit_out), 32'(q[head]));
            chk(fault == 1'b0, "R7 fault stays low", 32'(fault), 0);

            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            phase = (n / 80) % 4;
            case (phase)
                0:       begin do_push = 1'b1;     do_pop = 1'b0;     end
                1:       begin do_push = 1'b0;     do_pop = 1'b1;     end
                2:       begin do_push = lfsr[0];  do_pop = lfsr[1];  end
                default: begin do_push = 1'b1;     do_pop = lfsr[3];  end
            endcase
            push    = do_push;
            pop     = do_pop;
            flit_in = lfsr ^ 16'(n * 16'h0101);

            @(posedge clk);
            // Model update: push/pop ignored during a test (R6) and when
            // blocked by full/empty (R2).
            if (!exp_act) begin
                bit take_pop, take_push;
                take_pop  = do_pop && cnt > 0;
                take_push = do_push && cnt < D;
                if (take_push) q[(head + cnt) % D] = flit_in;
                if (take_pop) begin
                    head = (head + 1) % D;
                    cnt--;
                end
                if (take_push) cnt++;
            end
            @(negedge clk);
        end
        push = 1'b0;
        pop  = 1'b0;
        finish_run();
    end

endmodule